// File: doc/BRIEF.md
# Dual-CPU Interrupt Level Encoder

This block gathers the interrupt sources of a two-processor subsystem and gives each processor one encoded request level. A reset request is held in a word shared by both CPUs. Vertical-blank, horizontal-blank and PWM strobes each set a latched bit in a CPU's private word, but only where that CPU has enabled the source. A command request follows a software register bit for as long as that bit is set. Each CPU's level is twice the bit position of its highest pending bit. The level is computed combinationally and then registered, so the level pins never glitch.

Each CPU also holds one request from its internal peripherals, loaded as a level and a vector. When a CPU acknowledges, the block compares the external level with that internal level. It returns either an auto-vector or the stored internal vector. When the internal vector wins, the internal request is dropped and the level in force is recorded. A CPU that reports itself idle gets a wake signal while its level is nonzero. Software clears latched sources with write-one-to-clear strobes.

The pins carry control and status only. Acknowledge always completes in one cycle, so no pin has a valid/ready handshake and there is no back-pressure.

Top module: `irl_enc_top`

## Requirements
- R1: After reset, every level, vector, valid, recorded-level and wake output is zero.
- R2: A reset strobe sets the shared bit 7 whatever the enables are. Two cycles after the strobe, both CPUs show level 14.
- R3: The PWM, horizontal and vertical strobes latch into CPU n's private bits 3, 5 and 6 only if enable bits 0, 2 and 3 of that CPU (src_en_i[4n+j]) are set in the strobe's cycle. Otherwise the strobe leaves that CPU's level unchanged.
- R4: CPU n's private bit 4 (command) is set while enable bit 1 of CPU n and cmd_reg_i[n] are both high. One cycle after either drops, the level no longer counts it.
- R5: irl_o for CPU n, at bits [4n+3:4n], is twice the index of the highest pending bit in (shared OR private), or 0 if nothing is pending. It is valid one clock edge after the pending word.
- R6: clr_src_i[4n+j] clears the latched source that has enable index j. clr_rst_i clears the shared reset bit. A set in the same cycle wins over a clear. A clear of index 1 (command) does nothing.
- R7: ack_i[n] produces ack_valid_o[n] on the next edge. If the registered level is greater than CPU n's internal level, ack_vec_o[8n+7:8n] becomes 64 + level/2 and the internal request is kept.
- R8: If the level is not greater, the acknowledge returns the stored internal vector, clears the internal level to zero, and puts the current level on ack_cur_lvl_o.
- R9: wake_o[n] is high exactly when idle_i[n] is high and irl_o of CPU n is nonzero.
- R10: int_load_i[n] stores int_lvl_i and int_vec_i for CPU n. It takes priority over the auto-clear of an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rst_trig_i | input | 1 | Reset source strobe, never masked |
| vblank_trig_i | input | 1 | Vertical-blank source strobe |
| hblank_trig_i | input | 1 | Horizontal-blank source strobe |
| pwm_trig_i | input | 1 | PWM source strobe |
| src_en_i | input | 8 | Per-CPU enables, 4 bits per CPU |
| cmd_reg_i | input | 2 | Command register, one bit per CPU |
| clr_rst_i | input | 1 | Clears the shared reset bit |
| clr_src_i | input | 8 | Write-one-to-clear, 4 bits per CPU |
| ack_i | input | 2 | Interrupt acknowledge per CPU |
| int_load_i | input | 2 | Load internal request per CPU |
| int_lvl_i | input | 8 | Internal level, 4 bits per CPU |
| int_vec_i | input | 16 | Internal vector, 8 bits per CPU |
| idle_i | input | 2 | CPU is polling or sleeping |
| irl_o | output | 8 | Registered level, 4 bits per CPU |
| wake_o | output | 2 | Wake request per CPU |
| ack_valid_o | output | 2 | Vector valid, one cycle after ack |
| ack_vec_o | output | 16 | Returned vector, 8 bits per CPU |
| ack_cur_lvl_o | output | 8 | Level recorded on an internal acknowledge |

## Verification
A strobe reaches the level pins two edges after its cycle: one edge to latch the pending bit and one to register the level. A command-bit or enable change needs one edge, and an acknowledge shows its vector on the next edge. Wake follows irl_o in the same cycle. The bench drives inputs just after a rising edge and updates its reference model once per edge in that same order. It compares every output one time unit after the edge, so each result is checked in the cycle it is due.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int PEND_W   = 8;
  localparam int LVL_W    = 4;
  localparam int VEC_W    = 8;
  localparam int SRC_N    = 4;
  localparam int SRC_BASE = 3;
  localparam int CMD_IDX  = 1;
  localparam int RST_BIT  = 7;
  localparam logic [VEC_W-1:0] AUTO_BASE = 8'd64;

  function automatic logic [LVL_W-1:0] enc_level(input logic [PEND_W-1:0] p);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < PEND_W; i++)
      if (p[i]) r = LVL_W'(2 * i);
    return r;
  endfunction
endpackage

// File: rtl/irl_priv_pend.sv
module irl_priv_pend
  import irl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  trig_i,
  input  logic [SRC_N-1:0]  en_i,
  input  logic [SRC_N-1:0]  clr_i,
  input  logic              cmd_bit_i,
  output logic [PEND_W-1:0] pend_o
);
  logic [SRC_N-1:0] lat_q;

  for (genvar j = 0; j < SRC_N; j++) begin : g_src
    if (j == CMD_IDX) begin : g_cmd
      assign lat_q[j] = cmd_bit_i;
    end else begin : g_latch
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                bit_q <= 1'b0;
        else if (trig_i[j] & en_i[j]) bit_q <= 1'b1;
        else if (clr_i[j])          bit_q <= 1'b0;
      end
      assign lat_q[j] = bit_q;
    end
  end

  always_comb begin
    pend_o = '0;
    pend_o[SRC_BASE +: SRC_N] = lat_q;
  end
endmodule

// File: rtl/irl_level_reg.sv
module irl_level_reg
  import irl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PEND_W-1:0] pend_i,
  output logic [LVL_W-1:0]  lvl_o
);
  logic [LVL_W-1:0] lvl_d;
  assign lvl_d = enc_level(pend_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= '0;
    else         lvl_o <= lvl_d;
  end
endmodule

// File: rtl/irl_ack_unit.sv
module irl_ack_unit
  import irl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             load_i,
  input  logic [LVL_W-1:0] ld_lvl_i,
  input  logic [VEC_W-1:0] ld_vec_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic [LVL_W-1:0] int_lvl_o
);
  logic [VEC_W-1:0] int_vec_q;
  logic             ext_wins;
  logic [VEC_W-1:0] auto_vec;

  assign ext_wins = lvl_i > int_lvl_o;
  assign auto_vec = AUTO_BASE + VEC_W'(lvl_i >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      vec_o     <= '0;
      cur_lvl_o <= '0;
      int_lvl_o <= '0;
      int_vec_q <= '0;
    end else begin
      valid_o <= ack_i;
      if (ack_i) begin
        if (ext_wins) begin
          vec_o <= auto_vec;
        end else begin
          vec_o     <= int_vec_q;
          int_lvl_o <= '0;
          cur_lvl_o <= lvl_i;
        end
      end
      if (load_i) begin
        int_lvl_o <= ld_lvl_i;
        int_vec_q <= ld_vec_i;
      end
    end
  end
endmodule

// File: rtl/irl_enc_top.sv
module irl_enc_top
  import irl_pkg::*;
#(
  parameter int NCPU = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rst_trig_i,
  input  logic                  vblank_trig_i,
  input  logic                  hblank_trig_i,
  input  logic                  pwm_trig_i,
  input  logic [NCPU*SRC_N-1:0] src_en_i,
  input  logic [NCPU-1:0]       cmd_reg_i,
  input  logic                  clr_rst_i,
  input  logic [NCPU*SRC_N-1:0] clr_src_i,
  input  logic [NCPU-1:0]       ack_i,
  input  logic [NCPU-1:0]       int_load_i,
  input  logic [NCPU*LVL_W-1:0] int_lvl_i,
  input  logic [NCPU*VEC_W-1:0] int_vec_i,
  input  logic [NCPU-1:0]       idle_i,
  output logic [NCPU*LVL_W-1:0] irl_o,
  output logic [NCPU-1:0]       wake_o,
  output logic [NCPU-1:0]       ack_valid_o,
  output logic [NCPU*VEC_W-1:0] ack_vec_o,
  output logic [NCPU*LVL_W-1:0] ack_cur_lvl_o
);
  logic                  shared_rst_q;
  logic [SRC_N-1:0]      trig_vec;
  logic [NCPU*LVL_W-1:0] int_lvl_w;

  assign trig_vec = {vblank_trig_i, hblank_trig_i, 1'b0, pwm_trig_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shared_rst_q <= 1'b0;
    else if (rst_trig_i) shared_rst_q <= 1'b1;
    else if (clr_rst_i)  shared_rst_q <= 1'b0;
  end

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    logic [SRC_N-1:0]  en_n;
    logic [PEND_W-1:0] priv_pend;
    logic [PEND_W-1:0] all_pend;
    logic [LVL_W-1:0]  lvl_q;

    assign en_n = src_en_i[n*SRC_N +: SRC_N];

    irl_priv_pend u_priv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (trig_vec),
      .en_i      (en_n),
      .clr_i     (clr_src_i[n*SRC_N +: SRC_N]),
      .cmd_bit_i (en_n[CMD_IDX] & cmd_reg_i[n]),
      .pend_o    (priv_pend)
    );

    always_comb begin
      all_pend          = priv_pend;
      all_pend[RST_BIT] = priv_pend[RST_BIT] | shared_rst_q;
    end

    irl_level_reg u_lvl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (all_pend),
      .lvl_o  (lvl_q)
    );

    irl_ack_unit u_ack (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ack_i     (ack_i[n]),
      .lvl_i     (lvl_q),
      .load_i    (int_load_i[n]),
      .ld_lvl_i  (int_lvl_i[n*LVL_W +: LVL_W]),
      .ld_vec_i  (int_vec_i[n*VEC_W +: VEC_W]),
      .valid_o   (ack_valid_o[n]),
      .vec_o     (ack_vec_o[n*VEC_W +: VEC_W]),
      .cur_lvl_o (ack_cur_lvl_o[n*LVL_W +: LVL_W]),
      .int_lvl_o (int_lvl_w[n*LVL_W +: LVL_W])
    );

    assign irl_o[n*LVL_W +: LVL_W] = lvl_q;
    assign wake_o[n] = idle_i[n] & (lvl_q != '0);
  end
endmodule

// File: rtl/irl_enc_chk.sv
module irl_enc_chk
  import irl_pkg::*;
#(
  parameter int NCPU = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rst_trig_i,
  input logic                  shared_rst_q,
  input logic [NCPU*SRC_N-1:0] src_en_i,
  input logic [NCPU-1:0]       cmd_reg_i,
  input logic [NCPU-1:0]       ack_i,
  input logic [NCPU-1:0]       int_load_i,
  input logic [NCPU*LVL_W-1:0] int_lvl_w,
  input logic [NCPU*LVL_W-1:0] irl_o,
  input logic [NCPU-1:0]       ack_valid_o,
  input logic [NCPU*VEC_W-1:0] ack_vec_o
);
  // R2: reset strobe always reaches the shared word
  p_rst_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_trig_i |=> shared_rst_q);

  for (genvar n = 0; n < NCPU; n++) begin : g_a
    // R2: shared reset bit dominates the level of every CPU
    p_rst_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shared_rst_q |=> irl_o[n*LVL_W +: LVL_W] == 4'd14);
    // R4: command request gives at least level 8
    p_cmd_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_en_i[n*SRC_N+CMD_IDX] && cmd_reg_i[n]) |=> irl_o[n*LVL_W +: LVL_W] >= 4'd8);
    // R7: acknowledge returns a vector on the next edge
    p_ack_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[n] |=> ack_valid_o[n]);
    // R7: external level above internal gives the auto-vector
    p_auto_vec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[n] && irl_o[n*LVL_W +: LVL_W] > int_lvl_w[n*LVL_W +: LVL_W]) |=>
      ack_vec_o[n*VEC_W +: VEC_W] == 8'd64 + 8'($past(irl_o[n*LVL_W +: LVL_W]) >> 1));
    // R8: internal win without a load clears the internal level
    p_int_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[n] && !int_load_i[n] &&
       !(irl_o[n*LVL_W +: LVL_W] > int_lvl_w[n*LVL_W +: LVL_W])) |=>
      int_lvl_w[n*LVL_W +: LVL_W] == '0);
  end
endmodule

bind irl_enc_top irl_enc_chk #(.NCPU(NCPU)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_trig_i   (rst_trig_i),
  .shared_rst_q (shared_rst_q),
  .src_en_i     (src_en_i),
  .cmd_reg_i    (cmd_reg_i),
  .ack_i        (ack_i),
  .int_load_i   (int_load_i),
  .int_lvl_w    (int_lvl_w),
  .irl_o        (irl_o),
  .ack_valid_o  (ack_valid_o),
  .ack_vec_o    (ack_vec_o)
);

// File: tb/tb_irl_enc_top.sv
module tb_irl_enc_top;
  localparam int CLK_P = 10;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_trig = 0, vb_trig = 0, hb_trig = 0, pwm_trig = 0, clr_rst = 0;
  logic [7:0] src_en = '0, clr_src = '0, int_lvl = '0;
  logic [1:0] cmd_reg = '0, ack = '0, ld = '0, idle = '0;
  logic [15:0] int_vec = '0;
  logic [7:0] irl, cur;
  logic [1:0] wake, vvalid;
  logic [15:0] vec;

  int checks = 0, errors = 0;

  // reference model state
  logic       m_rst;
  logic [7:0] m_priv [N];
  logic [3:0] m_irl [N], m_il [N], m_cur [N];
  logic [7:0] m_iv [N], m_vec [N];
  logic       m_val [N];
  string      vtag [N];

  always #(CLK_P/2) clk = ~clk;

  irl_enc_top #(.NCPU(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_trig_i(rst_trig), .vblank_trig_i(vb_trig),
    .hblank_trig_i(hb_trig), .pwm_trig_i(pwm_trig), .src_en_i(src_en),
    .cmd_reg_i(cmd_reg), .clr_rst_i(clr_rst), .clr_src_i(clr_src), .ack_i(ack),
    .int_load_i(ld), .int_lvl_i(int_lvl), .int_vec_i(int_vec), .idle_i(idle),
    .irl_o(irl), .wake_o(wake), .ack_valid_o(vvalid), .ack_vec_o(vec),
    .ack_cur_lvl_o(cur));

  function automatic logic [3:0] lvl_of(input logic [7:0] p);
    logic [3:0] r = 0;
    for (int i = 7; i >= 1; i--) if (p[i]) begin r = 4'(2*i); break; end
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rst = 0;
    for (int n = 0; n < N; n++) begin
      m_priv[n] = 0; m_irl[n] = 0; m_il[n] = 0; m_cur[n] = 0;
      m_iv[n] = 0; m_vec[n] = 0; m_val[n] = 0; vtag[n] = "R7";
    end
  endtask

  task automatic model_edge();
    logic [3:0] trg;
    trg = {vb_trig, hb_trig, 1'b0, pwm_trig};
    for (int n = 0; n < N; n++) begin
      logic [7:0] p;
      logic [3:0] en;
      en = src_en[4*n +: 4];
      p = m_priv[n];
      p[4] = en[1] & cmd_reg[n];
      p[7] = m_rst;
      m_val[n] = ack[n];
      if (ack[n]) begin
        if (m_irl[n] > m_il[n]) begin
          m_vec[n] = 8'd64 + 8'(m_irl[n] >> 1); vtag[n] = "R7";
        end else begin
          m_vec[n] = m_iv[n]; m_il[n] = 0; m_cur[n] = m_irl[n]; vtag[n] = "R8";
        end
      end
      if (ld[n]) begin m_il[n] = int_lvl[4*n +: 4]; m_iv[n] = int_vec[8*n +: 8]; end
      m_irl[n] = lvl_of(p);
      for (int j = 0; j < 4; j++) begin
        if (j != 1) begin
          if (trg[j] & en[j]) m_priv[n][3+j] = 1'b1;
          else if (clr_src[4*n+j]) m_priv[n][3+j] = 1'b0;
        end
      end
    end
    if (rst_trig) m_rst = 1; else if (clr_rst) m_rst = 0;
  endtask

  task automatic check_all(input string ltag);
    for (int n = 0; n < N; n++) begin
      chk(ltag, irl[4*n +: 4], m_irl[n]);
      chk("R7", vvalid[n], m_val[n]);
      chk(vtag[n], vec[8*n +: 8], m_vec[n]);
      chk("R8", cur[4*n +: 4], m_cur[n]);
      chk("R9", wake[n], idle[n] && m_irl[n] != 0);
    end
  endtask

  task automatic step(input string ltag);
    @(posedge clk); #1;
    model_edge();
    check_all(ltag);
  endtask

  task automatic quiet();
    rst_trig = 0; vb_trig = 0; hb_trig = 0; pwm_trig = 0;
    clr_rst = 0; clr_src = 0; ack = 0; ld = 0;
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: everything zero out of reset
    check_all("R1");
    chk("R1", {irl, vec, cur, wake, vvalid}, 0);

    // R3: strobes with all enables off change nothing
    vb_trig = 1; hb_trig = 1; pwm_trig = 1; step("R3");
    quiet(); step("R3"); step("R3");
    chk("R3", irl, 0);

    // R3: vertical enabled only on CPU0
    src_en = 8'h08; vb_trig = 1; step("R3");
    quiet(); step("R3");
    chk("R3", irl[3:0], 12); chk("R3", irl[7:4], 0);

    // R2: reset strobe reaches both CPUs regardless of enables
    rst_trig = 1; step("R2");
    quiet(); step("R2");
    chk("R2", irl[3:0], 14); chk("R2", irl[7:4], 14);

    // R6: set beats clear, clear of command index ignored
    clr_rst = 1; clr_src = 8'h08; vb_trig = 1; step("R6");
    quiet(); step("R6");
    chk("R6", irl[3:0], 12); chk("R6", irl[7:4], 0);
    clr_src = 8'h0A; step("R6");
    quiet(); step("R6");
    chk("R6", irl[3:0], 0);

    // R4: command tracks register bit on CPU1
    src_en = 8'h20; cmd_reg = 2'b10; step("R4");
    chk("R4", irl[7:4], 8);
    cmd_reg = 2'b00; step("R4");
    chk("R4", irl[7:4], 0);

    // R7/R8/R10: acknowledge paths on CPU0
    src_en = 8'h08; vb_trig = 1; ld = 2'b01; int_lvl = 8'h05; int_vec = 16'h0033; step("R5");
    quiet(); step("R5");
    ack = 2'b01; step("R5");
    quiet();
    chk("R7", vec[7:0], 70);
    clr_src = 8'h08; step("R5"); quiet(); step("R5");
    ack = 2'b01; ld = 2'b01; int_lvl = 8'h09; int_vec = 16'h0044; step("R5");
    quiet();
    chk("R8", vec[7:0], 8'h33);
    ack = 2'b01; step("R5"); quiet();
    chk("R10", vec[7:0], 8'h44);

    // R9: idle wake
    idle = 2'b11; rst_trig = 1; step("R9"); quiet(); step("R9");
    chk("R9", wake, 2'b11);
    clr_rst = 1; step("R9"); quiet(); step("R9");
    chk("R9", wake, 2'b00);

    // R5: constrained random traffic
    void'($urandom(32'h1234_5678));
    for (int c = 0; c < 3000; c++) begin
      rst_trig = ($urandom % 40) == 0;
      vb_trig  = ($urandom % 6) == 0;
      hb_trig  = ($urandom % 6) == 0;
      pwm_trig = ($urandom % 6) == 0;
      clr_rst  = ($urandom % 4) == 0;
      clr_src  = 8'($urandom) & 8'($urandom);
      if ($urandom % 8 == 0) src_en = 8'($urandom);
      if ($urandom % 5 == 0) cmd_reg = 2'($urandom);
      ack     = 2'($urandom) & 2'($urandom);
      ld      = 2'($urandom) & 2'($urandom) & 2'($urandom);
      int_lvl = 8'($urandom);
      int_vec = 16'($urandom);
      idle    = 2'($urandom);
      step("R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule